// File: doc/BRIEF.md
# Multi-format floating-point operand unpacker to a 19-bit internal format

This block takes one floating-point operand per transfer, in half precision (1,5,10), bfloat16 (1,8,7) or single precision (1,8,23), and rewrites it into a single 19-bit internal operand. The internal operand has 1 sign bit, an 8-bit exponent with bias 127 and a 10-bit fraction. Because it has the exponent range of bfloat16 and the fraction width of half precision, one multiplier datapath built for this operand can serve both 16-bit formats. Single-precision operands are narrowed by truncation, so no rounding logic is needed.

Each converted operand comes with four class flags: zero, subnormal input, infinity and NaN. The 8-bit exponent can represent every half-precision subnormal as a normal number, so those inputs are renormalized. Operands enter and leave through valid/ready handshakes, with a single register stage between the two sides.

Top module: `fpu19_unpack`

## Requirements
- R1: `in_fmt` selects the input format: 0 is half precision in `in_data[15:0]`, 1 is bfloat16 in `in_data[15:0]`, and 2 or 3 is single precision in `in_data[31:0]`. For the two 16-bit formats, `in_data[31:16]` has no effect on the output.
- R2: A finite bfloat16 input with a nonzero exponent keeps its sign and its exponent. Its 7 fraction bits become `out_op[9:3]`, and `out_op[2:0]` is zero. `out_op` packs sign in bit 18, exponent in bits 17:10 and fraction in bits 9:0.
- R3: A half-precision input with an exponent field from 1 to 30 keeps its sign and its 10 fraction bits, and its exponent is increased by 112.
- R4: A half-precision input with a zero exponent and a nonzero fraction is renormalized. If L is the number of leading zeros in its 10-bit fraction, the fraction is shifted left by L+1 (keeping 10 bits), the exponent becomes 112−L and `out_sub` is set.
- R5: A finite single-precision input keeps its sign and exponent and takes the top 10 fraction bits. The lower 13 bits are dropped with no rounding.
- R6: An all-ones exponent with a zero fraction gives exponent 0xFF, fraction 0 and `out_inf`, with the sign kept.
- R7: An all-ones exponent with a nonzero fraction gives exponent 0xFF and sets `out_nan`. The fraction is the converted fraction with bit 9 forced to 1.
- R8: A zero input, meaning zero exponent and zero fraction, keeps its sign, gives exponent 0 and fraction 0, and sets `out_zero`.
- R9: A bfloat16 or single-precision input with a zero exponent and a nonzero fraction sets `out_sub`. It keeps exponent 0 and the converted fraction and is not renormalized. At most one class flag is ever set.
- R10: An operand accepted on a clock edge where `in_valid` and `in_ready` are both high appears on `out_op` with `out_valid` high after that edge.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output holds, whatever `in_data` does. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R12: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_fmt | input | 2 | Input format code |
| in_data | input | 32 | Input operand bits |
| out_valid | output | 1 | Converted operand present |
| out_ready | input | 1 | Consumer takes the operand this cycle |
| out_op | output | 19 | Converted operand {sign, exponent[7:0], fraction[9:0]} |
| out_zero | output | 1 | Input was zero |
| out_sub | output | 1 | Input was subnormal |
| out_inf | output | 1 | Input was infinity |
| out_nan | output | 1 | Input was NaN |

## Verification
Every converted operand and its flags are due exactly one rising edge after the handshake that accepts them. The bench drives inputs at a falling edge and compares the outputs at the next falling edge, with a bench reference function computing the expected values. The `in_ready` response to `out_ready` is combinational, so it is checked in the same half cycle in which `out_ready` changes. During backpressure, the held output is compared on every falling edge for several cycles while the input changes, and the held operand must appear one edge after `out_ready` rises.

// File: rtl/fpu19_pkg.sv
// Shared widths, format codes and result types for the 19-bit operand unpacker.
package fpu19_pkg;
    localparam int OP_EXP_W  = 8;
    localparam int OP_MAN_W  = 10;
    localparam int OP_W      = 1 + OP_EXP_W + OP_MAN_W;
    localparam int OP_BIAS   = 127;
    localparam int H_EXP_W   = 5;
    localparam int H_MAN_W   = 10;
    localparam int H_BIAS    = 15;
    localparam int B_MAN_W   = 7;
    localparam int S_MAN_W   = 23;
    localparam int IN_W      = 32;
    localparam int H_REBIAS  = OP_BIAS - H_BIAS;
    localparam int CLS_W     = 4;

    typedef enum logic [1:0] {
        FMT_HALF       = 2'd0,
        FMT_BRAIN      = 2'd1,
        FMT_SINGLE     = 2'd2,
        FMT_SINGLE_ALT = 2'd3
    } fmt_e;

    typedef struct packed {
        logic is_zero;
        logic is_sub;
        logic is_inf;
        logic is_nan;
    } cls_t;

    typedef struct packed {
        logic                sign;
        logic [OP_EXP_W-1:0] exp;
        logic [OP_MAN_W-1:0] man;
    } op19_t;

    typedef struct packed {
        op19_t op;
        cls_t  cls;
    } result_t;
endpackage

// File: rtl/fpu19_lzc.sv
// Leading-zero counter.
// Returns the number of zeros above the highest set bit of vec; W when vec is zero.
// Assumes W >= 1.
module fpu19_lzc #(
    parameter int W = 10,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    // Scan upward so the highest set bit wins.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpu19_convert.sv
// Combinational format converter.
// Splits the selected input format into its fields, classifies the operand,
// rebiases half-precision exponents, renormalizes half-precision subnormals
// and truncates single-precision fractions to the 10-bit internal fraction.
// Assumes the package widths (8-bit exponent, 10-bit fraction).
module fpu19_convert
    import fpu19_pkg::*;
(
    input  fmt_e             fmt,
    input  logic [IN_W-1:0]  data,
    output result_t          res
);
    localparam int LZ_W = $clog2(H_MAN_W + 1);

    logic                sign;
    logic [OP_EXP_W-1:0] exp_in;
    logic [OP_MAN_W-1:0] man_top;
    logic                man_low_nz;
    logic                exp_ones;
    logic                exp_zero;
    logic                is_half;
    logic                man_nz;
    logic [LZ_W-1:0]     lz;
    logic [OP_MAN_W-1:0] norm_man;
    logic [OP_EXP_W-1:0] norm_exp;

    // Field extraction per selected format.
    always_comb begin
        is_half    = 1'b0;
        man_low_nz = 1'b0;
        case (fmt)
            FMT_HALF: begin
                is_half  = 1'b1;
                sign     = data[15];
                exp_ones = &data[14:10];
                exp_zero = ~|data[14:10];
                exp_in   = OP_EXP_W'(data[14:10]) + OP_EXP_W'(H_REBIAS);
                man_top  = data[H_MAN_W-1:0];
            end
            FMT_BRAIN: begin
                sign     = data[15];
                exp_ones = &data[14:7];
                exp_zero = ~|data[14:7];
                exp_in   = data[14:7];
                man_top  = {data[B_MAN_W-1:0], {(OP_MAN_W-B_MAN_W){1'b0}}};
            end
            default: begin
                sign       = data[31];
                exp_ones   = &data[30:23];
                exp_zero   = ~|data[30:23];
                exp_in     = data[30:23];
                man_top    = data[S_MAN_W-1 -: OP_MAN_W];
                man_low_nz = |data[S_MAN_W-OP_MAN_W-1:0];
            end
        endcase
        man_nz = (|man_top) | man_low_nz;
    end

    fpu19_lzc #(.W(H_MAN_W)) u_lzc (
        .vec   (man_top),
        .count (lz)
    );

    // Half-precision subnormal renormalization: shift out the leading one.
    always_comb begin
        norm_man = OP_MAN_W'(man_top << (LZ_W'(lz) + LZ_W'(1)));
        norm_exp = OP_EXP_W'(H_REBIAS) - OP_EXP_W'(lz);
    end

    // Classification and final operand assembly.
    always_comb begin
        res.op.sign    = sign;
        res.op.exp     = exp_in;
        res.op.man     = man_top;
        res.cls        = '0;
        if (exp_ones) begin
            res.op.exp = '1;
            if (man_nz) begin
                res.cls.is_nan = 1'b1;
                res.op.man     = man_top | {1'b1, {(OP_MAN_W-1){1'b0}}};
            end else begin
                res.cls.is_inf = 1'b1;
                res.op.man     = '0;
            end
        end else if (exp_zero) begin
            res.op.exp = '0;
            if (!man_nz) begin
                res.cls.is_zero = 1'b1;
                res.op.man      = '0;
            end else begin
                res.cls.is_sub = 1'b1;
                if (is_half) begin
                    res.op.exp = norm_exp;
                    res.op.man = norm_man;
                end
            end
        end
    end
endmodule

// File: rtl/fpu19_pipe_reg.sv
// Single-entry handshake register.
// Loads when in_valid and in_ready are high; in_ready follows out_ready combinationally.
// Assumes the consumer holds out_ready independent of in_ready.
module fpu19_pipe_reg #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic         vld_q;
    logic [W-1:0] data_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = data_q;

    // Occupancy: refilled or drained whenever the stage may advance.
    always_ff @(posedge clk) begin
        if (!rst_n)        vld_q <= 1'b0;
        else if (in_ready) vld_q <= in_valid;
    end

    // Payload capture on an accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                     data_q <= '0;
        else if (in_valid && in_ready)  data_q <= in_data;
    end
endmodule

// File: rtl/fpu19_unpack.sv
// Top: converts one half, bfloat16 or single operand per transfer into the
// 19-bit internal operand plus class flags, with one registered stage.
// Assumes synchronous active-low reset.
module fpu19_unpack
    import fpu19_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          in_fmt,
    input  logic [IN_W-1:0]     in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [OP_W-1:0]     out_op,
    output logic                out_zero,
    output logic                out_sub,
    output logic                out_inf,
    output logic                out_nan
);
    localparam int RES_W = $bits(result_t);

    result_t conv_res;
    result_t held_res;

    fpu19_convert u_conv (
        .fmt  (fmt_e'(in_fmt)),
        .data (in_data),
        .res  (conv_res)
    );

    fpu19_pipe_reg #(.W(RES_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (conv_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (held_res)
    );

    // Unpack the registered result onto the ports.
    always_comb begin
        out_op   = held_res.op;
        out_zero = held_res.cls.is_zero;
        out_sub  = held_res.cls.is_sub;
        out_inf  = held_res.cls.is_inf;
        out_nan  = held_res.cls.is_nan;
    end
endmodule

// File: rtl/fpu19_unpack_chk.sv
// Property checker for fpu19_unpack, attached by bind.
module fpu19_unpack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [18:0] out_op,
    input logic        out_zero,
    input logic        out_sub,
    input logic        out_inf,
    input logic        out_nan
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_zero, out_sub, out_inf, out_nan})); // R9
    AST_INF_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_inf) |-> (out_op[17:0] == {8'hFF, 10'h000})); // R6
    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nan) |-> (out_op[17:10] == 8'hFF && out_op[9])); // R7
    AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (out_op[17:0] == 18'h0)); // R8
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R10
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) &&
            $stable({out_zero, out_sub, out_inf, out_nan}))); // R11
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R11
endmodule

bind fpu19_unpack fpu19_unpack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_op    (out_op),
    .out_zero  (out_zero),
    .out_sub   (out_sub),
    .out_inf   (out_inf),
    .out_nan   (out_nan)
);

// File: tb/fpu19_unpack_tb.sv
module fpu19_unpack_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_fmt = 2'd0;
    logic [31:0] in_data = 32'h0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [18:0] out_op;
    logic        out_zero, out_sub, out_inf, out_nan;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpu19_unpack u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_fmt(in_fmt), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_op(out_op), .out_zero(out_zero),
        .out_sub(out_sub), .out_inf(out_inf), .out_nan(out_nan)
    );

    // Reference: {zero, sub, inf, nan, sign, exp[7:0], man[9:0]}
    function automatic logic [22:0] ref_conv(input logic [1:0] f, input logic [31:0] d);
        logic s, z, sb, inf, nan;
        logic [7:0] e, ee;
        logic [9:0] m, hm;
        logic [4:0] he;
        logic [22:0] mf;
        int p, sh;
        z = 0; sb = 0; inf = 0; nan = 0; e = 0; m = 0;
        if (f == 2'd0) begin
            s = d[15]; he = d[14:10]; hm = d[9:0];
            if (he == 5'h1F) begin
                e = 8'hFF;
                if (hm == 0) inf = 1; else begin nan = 1; m = hm | 10'h200; end
            end else if (he == 0) begin
                if (hm == 0) z = 1;
                else begin
                    sb = 1; p = 0;
                    for (int k = 0; k < 10; k++) if (hm[k]) p = k;
                    sh = 10 - p;
                    m = 10'(hm << sh);
                    e = 8'(113 - sh);
                end
            end else begin
                e = 8'(he) + 8'd112; m = hm;
            end
        end else begin
            if (f == 2'd1) begin s = d[15]; ee = d[14:7]; mf = {d[6:0], 16'h0}; end
            else begin s = d[31]; ee = d[30:23]; mf = d[22:0]; end
            if (ee == 8'hFF) begin
                e = 8'hFF;
                if (mf == 0) inf = 1; else begin nan = 1; m = mf[22:13] | 10'h200; end
            end else if (ee == 0) begin
                if (mf == 0) z = 1; else begin sb = 1; m = mf[22:13]; end
            end else begin
                e = ee; m = mf[22:13];
            end
        end
        return {z, sb, inf, nan, s, e, m};
    endfunction

    function automatic logic [22:0] dut_vec();
        return {out_zero, out_sub, out_inf, out_nan, out_op};
    endfunction

    task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // Push one operand with out_ready high; result due one edge later.
    task automatic push_check(input string req, input logic [1:0] f, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_fmt = f; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 23'(out_valid), 23'd1);
        check(req, dut_vec(), ref_conv(f, d));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12 out_valid in reset", 23'(out_valid), 23'd0);
        check("R12 in_ready in reset", 23'(in_ready), 23'd1);
        rst_n = 1'b1;

        // R2 bfloat16 normals (0x3FC1 -> exp 7F, frac 0x208)
        push_check("R2", 2'd1, 32'h0000_3FC1);
        check("R2 hand value", {4'b0, out_op}, {4'b0, 1'b0, 8'h7F, 10'h208});
        push_check("R2", 2'd1, 32'h0000_C0A5);
        // R3 half normals (1.0 -> exp 127; max -> exp 142)
        push_check("R3", 2'd0, 32'h0000_3C00);
        check("R3 hand value", {4'b0, out_op}, {4'b0, 1'b0, 8'd127, 10'h000});
        push_check("R3", 2'd0, 32'h0000_7BFF);
        push_check("R3", 2'd0, 32'h0000_8401);
        // R4 half subnormals (0x0001 -> exp 103, frac 0)
        push_check("R4", 2'd0, 32'h0000_0001);
        check("R4 hand value", {4'b0, out_op}, {4'b0, 1'b0, 8'd103, 10'h000});
        push_check("R4", 2'd0, 32'h0000_0200);
        push_check("R4", 2'd0, 32'h0000_03FF);
        push_check("R4", 2'd0, 32'h0000_8155);
        // R5 single truncation, no rounding
        push_check("R5", 2'd2, 32'h3F80_1FFF);
        check("R5 no round", {4'b0, out_op}, {4'b0, 1'b0, 8'h7F, 10'h000});
        push_check("R5", 2'd2, 32'hBFFF_FFFF);
        // R6 infinities
        push_check("R6", 2'd0, 32'h0000_FC00);
        push_check("R6", 2'd1, 32'h0000_7F80);
        push_check("R6", 2'd2, 32'h7F80_0000);
        // R7 NaNs (payload only in dropped bits still NaN)
        push_check("R7", 2'd0, 32'h0000_7C01);
        push_check("R7", 2'd2, 32'h7F80_0001);
        check("R7 quiet bit", {4'b0, out_op}, {4'b0, 1'b0, 8'hFF, 10'h200});
        push_check("R7", 2'd1, 32'h0000_FFC1);
        // R8 signed zeros
        push_check("R8", 2'd0, 32'h0000_8000);
        push_check("R8", 2'd1, 32'h0000_0000);
        push_check("R8", 2'd2, 32'h8000_0000);
        // R9 wide-exponent subnormals are flagged, not renormalized
        push_check("R9", 2'd1, 32'h0000_0001);
        push_check("R9", 2'd2, 32'h0000_0001);
        push_check("R9", 2'd2, 32'h8040_0000);
        // R1 format codes and ignored upper bits
        push_check("R1", 2'd3, 32'h4049_0FDB);
        push_check("R1", 2'd0, 32'hABCD_3C00);
        check("R1 upper ignored", {4'b0, out_op}, {4'b0, 1'b0, 8'd127, 10'h000});
        push_check("R1", 2'd1, 32'hFFFF_3F80);

        // Random mix with forced special exponents; R9 flag exclusivity
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [1:0]  f;
            logic [31:0] d;
            int sel;
            f = 2'($urandom % 4);
            d = $urandom;
            sel = int'($urandom % 6);
            if (sel == 0) begin
                if (f == 2'd0) d[14:10] = 5'h00; else if (f == 2'd1) d[14:7] = 8'h00; else d[30:23] = 8'h00;
            end else if (sel == 1) begin
                if (f == 2'd0) d[14:10] = 5'h1F; else if (f == 2'd1) d[14:7] = 8'hFF; else d[30:23] = 8'hFF;
            end
            push_check("R1-random", f, d);
            check("R9 onehot flags", 23'($countones({out_zero, out_sub, out_inf, out_nan}) <= 1), 23'd1);
        end

        // R10/R11 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_fmt = 2'd0; in_data = 32'h0000_3555;
        @(negedge clk);
        check("R10 accepted", 23'(out_valid), 23'd1);
        check("R10 value", dut_vec(), ref_conv(2'd0, 32'h0000_3555));
        check("R11 in_ready low in stall", 23'(in_ready), 23'd0);
        in_fmt = 2'd2; in_data = 32'hC2F6_E979;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R11 hold", dut_vec(), ref_conv(2'd0, 32'h0000_3555));
            check("R11 valid held", 23'(out_valid), 23'd1);
            in_data = in_data ^ 32'h0F0F_0F0F;
        end
        in_data = 32'hC2F6_E979;
        out_ready = 1'b1;
        #1;
        check("R11 in_ready follows out_ready", 23'(in_ready), 23'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 next after stall", dut_vec(), ref_conv(2'd2, 32'hC2F6_E979));
        check("R10 valid after stall", 23'(out_valid), 23'd1);
        @(negedge clk);
        check("R11 drained", 23'(out_valid), 23'd0);
        check("R11 ready when empty", 23'(in_ready), 23'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule